// File: doc/BRIEF.md
# Three-Lane PRBS Symbol Checker

This block watches three parallel serial-link lanes that carry 10-bit symbols. For each lane it decides whether the traffic is the pseudo-random sequence that was selected for that lane, and how many bit errors that traffic holds. Each lane can use one of four polynomials. Each lane can also read the bits of a symbol in either order. A lane takes its starting state from the first symbols it receives. After that it runs its own reference generator and compares each new symbol against the symbol it predicts. Every mismatched bit is added to a lane error meter, which software can clear or freeze while the lane runs.

Errors are also collected over a window of checked symbols. The length of the window and an error threshold are shared by all lanes. When a window closes, each lane reports a 2-bit verdict: pass or fail.

The lane configuration (polynomial, width, bit order) is taken in while the `hold` input is high. The window length and the threshold are taken in at the same time. The checker then starts from a clean state when `hold` falls. The clear bit and the freeze bit are read live on every cycle.

Top module: `prbs_trio_checker`

## Requirements
- R1: While `hold` is high, each clock edge captures the lane configuration and the window controls, and returns every lane to a clean state: meter 0, verdict 00, unseeded. Changes to the polynomial, width or bit-order fields while `hold` is low have no effect until the next time `hold` is high.
- R2: Lane n is controlled by `ctrl_lane[8n+7:8n]`. In that byte, [7:6] selects the polynomial, [5:4] is the width, [3] is clear, [2] is freeze and [1] is reverse. The polynomial codes are: 0 = x^11+x^9+1, 1 = x^15+x^14+1, 2 = x^7+x^6+1, 3 = x^31+x^28+1. In sequence terms, code 2 means b[n] = b[n-7] ^ b[n-6], and so on for the other codes.
- R3: After `hold` falls, the first ceil(degree/10) valid symbols of a lane are taken as its seed and add no errors. From then on, each valid symbol adds the number of bits in which it differs from the lane's own free-running prediction. A corrupted symbol never disturbs the prediction of later symbols.
- R4: With reverse = 0, bit 0 of a symbol is the earliest bit of the sequence. With reverse = 1, bit 9 is the earliest.
- R5: A lane is checked only when its captured width field is 3 (10-bit symbols). Any other width leaves the lane idle, with meter 0 and verdict 00.
- R6: While a lane's clear bit is 1, its meter reads 0 from the next clock edge on. Clear takes priority over freeze.
- R7: While a lane's freeze bit is 1 and its clear bit is 0, its meter keeps its value and the errors it sees are dropped.
- R8: A lane meter stops at 2^16-1 and does not wrap.
- R9: The window length is `ctrl_win[19:8]` + 1 checked symbols. The threshold is `ctrl_win[7:0]`. When a window closes, the lane verdict becomes 01 if the errors in that window are at or below the threshold, and 10 if they are above it. The verdict stays 00 until the first window closes. Lane n's verdict is `lock_sts[2n+1:2n]`, so three passing lanes read 0x15.
- R10: Lanes are independent: errors on one lane do not change the meter or verdict of another lane.
- R11: A cycle with `sym_valid` low advances no lane state, whatever is on `sym_data`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hold | input | 1 | Checker held clean while the configuration is captured |
| ctrl_lane | input | 24 | One control byte per lane |
| ctrl_win | input | 20 | Window length minus one [19:8], error threshold [7:0] |
| sym_valid | input | 1 | A symbol is present on every lane this cycle |
| sym_data | input | 30 | Lane n symbol at [10n+9:10n] |
| lock_sts | output | 6 | 2-bit verdict per lane |
| err_cnt | output | 48 | Lane n bit-error meter at [16n+15:16n] |

## Verification
The hardest state to reach from the ports is a full meter, because 65535 bit errors must pile up on one lane without the lane ever losing its reference. The bench reaches it by inverting all ten bits of every symbol on lane 0 for several thousand symbols. Since the reference generator runs freely after seeding, every symbol adds exactly ten errors. The bench can therefore predict the count at which the meter stops. Window verdicts need the seed symbols and the window boundaries counted symbol by symbol. The bench does this by injecting errors just at and just above the threshold inside one window, and by checking the verdict again one symbol before that window closes.

// File: rtl/prbs_chk_pkg.sv
package prbs_chk_pkg;

   // polynomial select codes
   typedef enum logic [1:0] {
      POLY_P11 = 2'd0,
      POLY_P15 = 2'd1,
      POLY_P7  = 2'd2,
      POLY_P31 = 2'd3
   } poly_e;

   // per-lane control byte, msb first
   typedef struct packed {
      poly_e      poly;
      logic [1:0] width;
      logic       clr;
      logic       frz;
      logic       rev;
      logic       spare;
   } lane_ctl_t;

   typedef enum logic [1:0] {
      VERD_NONE = 2'b00,
      VERD_PASS = 2'b01,
      VERD_FAIL = 2'b10
   } verdict_e;

   localparam int HIST_W     = 31;
   localparam int LANE_CTL_W = $bits(lane_ctl_t);
   localparam logic [1:0] WIDTH_FULL = 2'd3;

   // recurrence taps: b[n] = b[n-A] ^ b[n-B]
   localparam int P7_A  = 7;
   localparam int P7_B  = 6;
   localparam int P11_A = 11;
   localparam int P11_B = 9;
   localparam int P15_A = 15;
   localparam int P15_B = 14;
   localparam int P31_A = 31;
   localparam int P31_B = 28;

   function automatic int poly_degree(input poly_e p);
      case (p)
         POLY_P7:  return P7_A;
         POLY_P11: return P11_A;
         POLY_P15: return P15_A;
         default:  return P31_A;
      endcase
   endfunction

endpackage

// File: rtl/prbs_sym_predict.sv
module prbs_sym_predict
   import prbs_chk_pkg::*;
#(
   parameter int SYM_W = 10
) (
   input  poly_e              poly,
   input  logic               seeding,
   input  logic [HIST_W-1:0]  hist_q,
   input  logic [SYM_W-1:0]   rx_bits,
   output logic [HIST_W-1:0]  hist_d,
   output logic [SYM_W-1:0]   mism
);

   logic [HIST_W-1:0] h;
   logic              nb;

   always_comb begin
      h    = hist_q;
      mism = '0;
      nb   = 1'b0;
      for (int k = 0; k < SYM_W; k++) begin
         case (poly)
            POLY_P7:  nb = h[P7_A-1]  ^ h[P7_B-1];
            POLY_P11: nb = h[P11_A-1] ^ h[P11_B-1];
            POLY_P15: nb = h[P15_A-1] ^ h[P15_B-1];
            default:  nb = h[P31_A-1] ^ h[P31_B-1];
         endcase
         if (seeding) begin
            h = {h[HIST_W-2:0], rx_bits[k]};
         end else begin
            mism[k] = nb ^ rx_bits[k];
            h       = {h[HIST_W-2:0], nb};
         end
      end
      hist_d = h;
   end

endmodule

// File: rtl/prbs_err_meter.sv
module prbs_err_meter #(
   parameter int CNT_W = 16,
   parameter int ADD_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hold,
   input  logic             clr,
   input  logic             frz,
   input  logic             add_en,
   input  logic [ADD_W-1:0] add_val,
   output logic [CNT_W-1:0] cnt
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [CNT_W:0] sum;

   generate
      if (ADD_W > CNT_W) begin : g_bad_w
         $error("prbs_err_meter: ADD_W must not exceed CNT_W");
      end
   endgenerate

   always_comb sum = {1'b0, cnt} + (CNT_W+1)'(add_val);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (hold || clr) begin
         cnt <= '0;
      end else if (!frz && add_en) begin
         cnt <= sum[CNT_W] ? CNT_MAX : sum[CNT_W-1:0];
      end
   end

   assert_clear_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> cnt == '0);
   assert_freeze_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold && !clr && frz) |=> $stable(cnt));
   assert_no_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold && !clr && cnt == CNT_MAX) |=> cnt == CNT_MAX);
   assert_monotone_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold && !clr) |=> cnt >= $past(cnt));

endmodule

// File: rtl/prbs_win_judge.sv
module prbs_win_judge
   import prbs_chk_pkg::*;
#(
   parameter int WIN_W = 12,
   parameter int THR_W = 8,
   parameter int ADD_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hold,
   input  logic [WIN_W-1:0] win_last,
   input  logic [THR_W-1:0] thr,
   input  logic             step,
   input  logic [ADD_W-1:0] err_add,
   output verdict_e         verdict
);

   localparam int ACC_W = THR_W + 1;
   localparam logic [ACC_W-1:0] ACC_MAX = '1;

   logic [WIN_W-1:0] win_cnt;
   logic [ACC_W-1:0] acc;
   logic [ACC_W:0]   acc_sum;
   logic [ACC_W-1:0] acc_sat;
   logic             closing;

   always_comb begin
      acc_sum = {1'b0, acc} + (ACC_W+1)'(err_add);
      acc_sat = acc_sum[ACC_W] ? ACC_MAX : acc_sum[ACC_W-1:0];
      closing = step && (win_cnt == win_last);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_cnt <= '0;
         acc     <= '0;
         verdict <= VERD_NONE;
      end else if (hold) begin
         win_cnt <= '0;
         acc     <= '0;
         verdict <= VERD_NONE;
      end else if (closing) begin
         win_cnt <= '0;
         acc     <= '0;
         verdict <= (acc_sat <= ACC_W'(thr)) ? VERD_PASS : VERD_FAIL;
      end else if (step) begin
         win_cnt <= win_cnt + 1'b1;
         acc     <= acc_sat;
      end
   end

   assert_legal_verdict_R9: assert property (@(posedge clk) disable iff (!rst_n)
      verdict != 2'b11);
   assert_hold_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> verdict == VERD_NONE);
   assert_verdict_at_close_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold && !closing) |=> $stable(verdict));

endmodule

// File: rtl/prbs_lane.sv
module prbs_lane
   import prbs_chk_pkg::*;
#(
   parameter int SYM_W = 10,
   parameter int CNT_W = 16,
   parameter int WIN_W = 12,
   parameter int THR_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hold,
   input  lane_ctl_t        ctl,
   input  logic [WIN_W-1:0] win_last,
   input  logic [THR_W-1:0] thr,
   input  logic             sym_valid,
   input  logic [SYM_W-1:0] sym,
   output verdict_e         verdict,
   output logic [CNT_W-1:0] cnt
);

   localparam int ADD_W  = $clog2(SYM_W + 1);
   localparam int SEED_W = $clog2(HIST_W / SYM_W + 2);

   poly_e             cfg_poly;
   logic              cfg_rev;
   logic              cfg_act;
   logic              seeded;
   logic [SEED_W-1:0] seed_cnt;
   logic [HIST_W-1:0] hist_q;
   logic [HIST_W-1:0] hist_d;
   logic [SYM_W-1:0]  rx_bits;
   logic [SYM_W-1:0]  mism;
   logic [ADD_W-1:0]  pop;
   logic              take;
   logic              check;
   int                seed_need;

   // time-order the symbol bits
   generate
      for (genvar k = 0; k < SYM_W; k++) begin : g_order
         assign rx_bits[k] = cfg_rev ? sym[SYM_W-1-k] : sym[k];
      end
   endgenerate

   always_comb begin
      seed_need = (poly_degree(cfg_poly) + SYM_W - 1) / SYM_W;
      take      = sym_valid && cfg_act && !hold;
      check     = take && seeded;
      pop       = '0;
      for (int k = 0; k < SYM_W; k++) pop = pop + ADD_W'(mism[k]);
   end

   prbs_sym_predict #(.SYM_W(SYM_W)) u_pred (
      .poly    (cfg_poly),
      .seeding (!seeded),
      .hist_q  (hist_q),
      .rx_bits (rx_bits),
      .hist_d  (hist_d),
      .mism    (mism)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_poly <= POLY_P11;
         cfg_rev  <= 1'b0;
         cfg_act  <= 1'b0;
         seeded   <= 1'b0;
         seed_cnt <= '0;
         hist_q   <= '0;
      end else if (hold) begin
         cfg_poly <= ctl.poly;
         cfg_rev  <= ctl.rev;
         cfg_act  <= (ctl.width == WIDTH_FULL);
         seeded   <= 1'b0;
         seed_cnt <= '0;
         hist_q   <= '0;
      end else if (take) begin
         hist_q <= hist_d;
         if (!seeded) begin
            seed_cnt <= seed_cnt + 1'b1;
            if (int'(seed_cnt) + 1 >= seed_need) seeded <= 1'b1;
         end
      end
   end

   prbs_err_meter #(.CNT_W(CNT_W), .ADD_W(ADD_W)) u_meter (
      .clk     (clk),
      .rst_n   (rst_n),
      .hold    (hold),
      .clr     (ctl.clr),
      .frz     (ctl.frz),
      .add_en  (check),
      .add_val (pop),
      .cnt     (cnt)
   );

   prbs_win_judge #(.WIN_W(WIN_W), .THR_W(THR_W), .ADD_W(ADD_W)) u_judge (
      .clk      (clk),
      .rst_n    (rst_n),
      .hold     (hold),
      .win_last (win_last),
      .thr      (thr),
      .step     (check),
      .err_add  (pop),
      .verdict  (verdict)
   );

   assert_idle_lane_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold && !cfg_act) |=> (cnt == '0 && verdict == VERD_NONE));
   assert_invalid_still_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold && !sym_valid) |=> ($stable(hist_q) && $stable(seeded)));
   assert_seed_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold && !seeded && !ctl.clr) |=> $stable(cnt));

endmodule

// File: rtl/prbs_trio_checker.sv
module prbs_trio_checker
   import prbs_chk_pkg::*;
#(
   parameter int NUM_LANES = 3,
   parameter int SYM_W     = 10,
   parameter int CNT_W     = 16,
   parameter int WIN_W     = 12,
   parameter int THR_W     = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          hold,
   input  logic [NUM_LANES*8-1:0]        ctrl_lane,
   input  logic [WIN_W+THR_W-1:0]        ctrl_win,
   input  logic                          sym_valid,
   input  logic [NUM_LANES*SYM_W-1:0]    sym_data,
   output logic [NUM_LANES*2-1:0]        lock_sts,
   output logic [NUM_LANES*CNT_W-1:0]    err_cnt
);

   logic [WIN_W-1:0] win_last_q;
   logic [THR_W-1:0] thr_q;

   generate
      if (NUM_LANES < 1) begin : g_chk_lanes
         $error("prbs_trio_checker: NUM_LANES must be at least 1");
      end
      if (LANE_CTL_W != 8) begin : g_chk_ctl
         $error("prbs_trio_checker: lane control must be one byte");
      end
      if (SYM_W < 1 || SYM_W > 64) begin : g_chk_sym
         $error("prbs_trio_checker: SYM_W out of range");
      end
      if (CNT_W < $clog2(SYM_W + 1)) begin : g_chk_cnt
         $error("prbs_trio_checker: CNT_W too narrow");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_last_q <= '0;
         thr_q      <= '0;
      end else if (hold) begin
         win_last_q <= ctrl_win[WIN_W+THR_W-1:THR_W];
         thr_q      <= ctrl_win[THR_W-1:0];
      end
   end

   generate
      for (genvar n = 0; n < NUM_LANES; n++) begin : g_lane
         verdict_e verdict_n;

         prbs_lane #(
            .SYM_W (SYM_W),
            .CNT_W (CNT_W),
            .WIN_W (WIN_W),
            .THR_W (THR_W)
         ) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .hold      (hold),
            .ctl       (lane_ctl_t'(ctrl_lane[8*n +: 8])),
            .win_last  (win_last_q),
            .thr       (thr_q),
            .sym_valid (sym_valid),
            .sym       (sym_data[SYM_W*n +: SYM_W]),
            .verdict   (verdict_n),
            .cnt       (err_cnt[CNT_W*n +: CNT_W])
         );

         assign lock_sts[2*n +: 2] = verdict_n;
      end
   endgenerate

   assert_hold_meters_R1: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> (err_cnt == '0 && lock_sts == '0));

endmodule

// File: tb/prbs_trio_checker_bench.sv
`timescale 1ns/1ps
module prbs_trio_checker_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        hold = 1'b0;
   logic [23:0] ctrl_lane = '0;
   logic [19:0] ctrl_win = '0;
   logic        sym_valid = 1'b0;
   logic [29:0] sym_data = '0;
   logic [5:0]  lock_sts;
   logic [47:0] err_cnt;

   int total = 0;
   int bad = 0;

   logic [30:0] gh [3];
   logic [1:0]  gpoly [3];
   logic        grev [3];

   always #5 clk = ~clk;

   prbs_trio_checker u_prbs_trio_checker (
      .clk       (clk),
      .rst_n     (rst_n),
      .hold      (hold),
      .ctrl_lane (ctrl_lane),
      .ctrl_win  (ctrl_win),
      .sym_valid (sym_valid),
      .sym_data  (sym_data),
      .lock_sts  (lock_sts),
      .err_cnt   (err_cnt)
   );

   function automatic logic [7:0] lb(input logic [1:0] mode, input logic [1:0] w,
                                     input logic clr, input logic frz, input logic rev);
      return {mode, w, clr, frz, rev, 1'b0};
   endfunction

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] cnt_of(input int n);
      return err_cnt[16*n +: 16];
   endfunction

   // next sequence bit of a lane, per the recurrences of R2
   task automatic gen_bit(input int l, output logic b);
      case (gpoly[l])
         2'd0: b = gh[l][10] ^ gh[l][8];
         2'd1: b = gh[l][14] ^ gh[l][13];
         2'd2: b = gh[l][6] ^ gh[l][5];
         default: b = gh[l][30] ^ gh[l][27];
      endcase
      gh[l] = {gh[l][29:0], b};
   endtask

   task automatic cfg(input logic [23:0] lanes, input logic [19:0] win);
      @(negedge clk);
      hold = 1'b1;
      ctrl_lane = lanes;
      ctrl_win = win;
      for (int l = 0; l < 3; l++) begin
         gh[l] = '1;
         gpoly[l] = lanes[8*l+6 +: 2];
         grev[l] = lanes[8*l+1];
      end
      @(negedge clk);
      @(negedge clk);
      hold = 1'b0;
   endtask

   // one symbol per lane, XORed with a flip mask
   task automatic push(input logic [9:0] f0, input logic [9:0] f1, input logic [9:0] f2);
      logic [9:0] s;
      logic [9:0] f [3];
      logic b;
      f[0] = f0; f[1] = f1; f[2] = f2;
      for (int l = 0; l < 3; l++) begin
         s = '0;
         for (int k = 0; k < 10; k++) begin
            gen_bit(l, b);
            if (grev[l]) s[9-k] = b; else s[k] = b;
         end
         sym_data[10*l +: 10] = s ^ f[l];
      end
      sym_valid = 1'b1;
      @(negedge clk);
      sym_valid = 1'b0;
   endtask

   task automatic push_clean(input int n);
      for (int i = 0; i < n; i++) push('0, '0, '0);
   endtask

   task automatic t_reset;
      chk("R1 reset meters", err_cnt, 48'h0);
      chk("R1 reset verdict", lock_sts, 6'h0);
   endtask

   task automatic t_basic;
      cfg({lb(2'd2, 2'd3, 0, 0, 0), lb(2'd1, 2'd3, 0, 0, 0), lb(2'd0, 2'd3, 0, 0, 0)}, 20'h0FF_10);
      push_clean(20);
      chk("R3 clean stream lanes 0..2", err_cnt, 48'h0);
      push(10'h001, 10'h007, 10'h000);
      push_clean(10);
      chk("R3 lane0 single error no spread", cnt_of(0), 16'd1);
      chk("R10 lane1 three errors", cnt_of(1), 16'd3);
      chk("R10 lane2 untouched", cnt_of(2), 16'd0);
   endtask

   task automatic t_reverse;
      cfg({lb(2'd3, 2'd3, 0, 0, 0), lb(2'd2, 2'd3, 0, 0, 1), lb(2'd3, 2'd3, 0, 0, 1)}, 20'h0FF_10);
      push_clean(20);
      chk("R4 reversed and PRBS31 lanes clean", err_cnt, 48'h0);
      // lane 0 expects reversed order but receives natural order
      cfg({lb(2'd3, 2'd3, 0, 0, 0), lb(2'd2, 2'd3, 0, 0, 0), lb(2'd2, 2'd3, 0, 0, 1)}, 20'h0FF_10);
      grev[0] = 1'b0;
      push_clean(20);
      total++;
      if (cnt_of(0) == 16'd0) begin
         bad++;
         $display("FAIL R4 wrong bit order: actual=0x0 expected=nonzero");
      end
      chk("R4 other lanes clean", cnt_of(1), 16'd0);
   endtask

   task automatic t_window;
      // window of 4 symbols, threshold 2, all lanes PRBS7 (seed = 1 symbol)
      cfg({lb(2'd2, 2'd3, 0, 0, 0), lb(2'd2, 2'd3, 0, 0, 0), lb(2'd2, 2'd3, 0, 0, 0)}, 20'h003_02);
      push_clean(4);
      chk("R9 no verdict before first window", lock_sts, 6'h00);
      push_clean(1);
      chk("R9 all pass", lock_sts, 6'h15);
      push(10'h007, 10'h003, 10'h000);
      push_clean(2);
      chk("R9 verdict held mid window", lock_sts, 6'h15);
      push_clean(1);
      chk("R9 above threshold fails, at threshold passes", lock_sts, 6'h16);
   endtask

   task automatic t_width;
      cfg({lb(2'd2, 2'd3, 0, 0, 0), lb(2'd2, 2'd2, 0, 0, 0), lb(2'd2, 2'd3, 0, 0, 0)}, 20'h003_02);
      push('0, 10'h3FF, '0);
      push('0, 10'h3FF, '0);
      push_clean(3);
      chk("R5 idle lane meter", cnt_of(1), 16'd0);
      chk("R5 idle lane verdict", lock_sts, 6'h11);
   endtask

   task automatic t_clear_freeze;
      cfg({lb(2'd0, 2'd3, 0, 0, 0), lb(2'd0, 2'd3, 0, 0, 0), lb(2'd0, 2'd3, 0, 0, 0)}, 20'h0FF_10);
      push_clean(3);
      push(10'h00F, 10'h003, 10'h000);
      chk("R7 pre freeze lane1", cnt_of(1), 16'd2);
      ctrl_lane[3] = 1'b1;
      ctrl_lane[2] = 1'b1;
      ctrl_lane[10] = 1'b1;
      @(negedge clk);
      chk("R6 clear beats freeze", cnt_of(0), 16'd0);
      push(10'h0FF, 10'h00F, 10'h000);
      chk("R6 cleared while errors", cnt_of(0), 16'd0);
      chk("R7 frozen lane1", cnt_of(1), 16'd2);
      ctrl_lane[3] = 1'b0;
      ctrl_lane[2] = 1'b0;
      ctrl_lane[10] = 1'b0;
      push(10'h003, 10'h001, 10'h000);
      chk("R6 counts after clear", cnt_of(0), 16'd2);
      chk("R7 counts after thaw", cnt_of(1), 16'd3);
   endtask

   task automatic t_live_cfg_and_idle;
      cfg({lb(2'd2, 2'd3, 0, 0, 0), lb(2'd2, 2'd3, 0, 0, 0), lb(2'd2, 2'd3, 0, 0, 0)}, 20'h0FF_10);
      push_clean(3);
      ctrl_lane[7:6] = 2'd3;
      ctrl_lane[1] = 1'b1;
      ctrl_lane[13:12] = 2'd0;
      push_clean(8);
      chk("R1 live config ignored", err_cnt, 48'h0);
      for (int i = 0; i < 5; i++) begin
         sym_data = 30'h2AAA_5555 ^ 30'(i * 977);
         @(negedge clk);
      end
      push_clean(5);
      chk("R11 invalid cycles ignored", err_cnt, 48'h0);
   endtask

   task automatic t_saturate;
      cfg({lb(2'd2, 2'd3, 0, 0, 0), lb(2'd2, 2'd3, 0, 0, 0), lb(2'd2, 2'd3, 0, 0, 0)}, 20'hFFF_FF);
      push_clean(1);
      for (int i = 0; i < 6560; i++) push(10'h3FF, '0, '0);
      chk("R8 meter stops at max", cnt_of(0), 16'hFFFF);
      chk("R10 neighbour lane clean", cnt_of(1), 16'd0);
   endtask

   initial begin
      #(1_500_000);
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      for (int l = 0; l < 3; l++) begin
         gh[l] = '1; gpoly[l] = '0; grev[l] = 1'b0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic();
      t_reverse();
      t_window();
      t_width();
      t_clear_freeze();
      t_live_cfg_and_idle();
      t_saturate();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule